// File: doc/BRIEF.md
# Linear-to-physical address translator with TLB and two-level table walk

This block turns a 32-bit linear address into a physical address for a processor's memory pipeline. It first compares the address against a small fully associative translation cache of recently used pages. When the cache holds the page, the physical address comes back in the next cycle without touching memory. When the cache misses, the block reads the translation from a two-level table in memory through a single request/acknowledge port. It reads one directory word and, for an ordinary page, one table word. It then fills the cache and reports either the physical address or a fault.

Both 4 KB pages and 4 MB pages are supported, and they can be mixed within one directory. While walking, the block writes the used-page flag and the modified-page flag back into the table words when they are not yet set. A write to a cached page that is not yet marked modified therefore goes through the walk again, so that memory records the modification. Only one translation is in progress at a time. Each translation ends with a one-cycle `res_done` or `res_fault` pulse. A software flush strobe empties the cache in one cycle.

Top module: `page_walker`

## Requirements
- R1: A linear address splits into a directory index (bits 31:22), a table index (bits 21:12) and a byte offset (bits 11:0). The directory word is read at `{dir_base[31:12], index, 2'b00}` and the table word at `{dirword[31:12], table index, 2'b00}`. The memory address and write flag stay stable while a request waits for its acknowledge.
- R2: For a 4 KB page the physical address is the table word's bits 31:12 followed by the address's bits 11:0.
- R3: A present directory word with bit 7 set maps a 4 MB page directly. No table word is read, and the physical address is dirword[31:22] followed by address bits 21:0.
- R4: If bit 0 (present) is clear in the directory word or in the table word, the translation ends with `res_fault`, and the non-present word is not written.
- R5: After any successful translation, bit 5 (used) is set in the directory word and in the table word, written back only when it was clear. On a write, bit 6 (modified) is set in the leaf word: the table word, or the directory word for a 4 MB page. A non-leaf directory word never gets bit 6.
- R6: A user access (`req_user`=1) faults when bit 2 is clear in either level's word. A user write also faults when bit 1 is clear in either word. Supervisor accesses ignore both bits.
- R7: An access that hits the cache, and that is not a write to an unmodified page, finishes in the cycle after it is accepted, with no memory request.
- R8: The cache holds 32 translations and replaces them in round-robin order. After 33 distinct pages are filled following a flush, the first page misses and the third still hits.
- R9: One cycle of `flush` invalidates every cache entry, so the next access to any page walks.
- R10: A write that hits a cached page whose modified flag is clear walks again, sets bit 6 in memory, and updates that same cache entry. A later write to the page then hits.
- R11: Each accepted request produces exactly one one-cycle pulse of either `res_done` or `res_fault`, never both. `busy` is high while a walk is in progress, and `req_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, accepted when `busy` is low |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user-level access, 0 = supervisor |
| dir_base | input | 32 | Directory base address (bits 31:12 used) |
| flush | input | 1 | Invalidate all cache entries |
| busy | output | 1 | A table walk is in progress |
| res_done | output | 1 | One-cycle pulse: translation succeeded |
| res_fault | output | 1 | One-cycle pulse: page fault |
| res_paddr | output | 32 | Physical address, valid with `res_done` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write `mem_wdata`, 0 = read |
| mem_addr | output | 32 | Word address of the table entry |
| mem_wdata | output | 32 | Updated entry value for write-back |
| mem_ack | input | 1 | Memory completes the current request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The hardest case to reach from the ports is round-robin replacement. Evicting one particular entry needs 33 distinct pages filled after a flush. The bench builds a 40-entry table for this and walks it in order, then probes the first and third pages. Write hits on cached but unmodified pages are also hard to reach by chance. Directed sequences produce them (read, then write, then write again), and random traffic over a small page set with random modified flags produces more. The memory model inserts random acknowledge delays throughout.

// File: rtl/page_walker.sv
module page_walker #(
  parameter int TLB_N = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic        req_user,
  input  logic [31:0] dir_base,
  input  logic        flush,
  output logic        busy,
  output logic        res_done,
  output logic        res_fault,
  output logic [31:0] res_paddr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int IW = $clog2(TLB_N);
  localparam int B_P = 0, B_RW = 1, B_US = 2, B_A = 5, B_D = 6, B_PS = 7;

  typedef enum logic [2:0] {S_IDLE, S_DRD, S_DCHK, S_DWR, S_TRD, S_TCHK, S_TWR} st_t;
  st_t st;

  logic [31:0] va, ent, pde_q;
  logic        wr_q, usr_q, refill_hit;
  logic [IW-1:0] fill_idx, rr;

  logic [TLB_N-1:0] tv;
  logic [19:0] t_vpn [TLB_N];
  logic [19:0] t_frm [TLB_N];
  logic        t_big [TLB_N];
  logic        t_rw  [TLB_N];
  logic        t_us  [TLB_N];
  logic        t_d   [TLB_N];

  logic          hit;
  logic [IW-1:0] hidx;
  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = TLB_N - 1; i >= 0; i--) begin
      if (tv[i] && (t_big[i] ? (t_vpn[i][19:10] == req_addr[31:22])
                             : (t_vpn[i] == req_addr[31:12]))) begin
        hit  = 1'b1;
        hidx = IW'(i);
      end
    end
  end

  wire hit_ok    = hit && !flush;
  wire h_perm    = req_user && (!t_us[hidx] || (req_write && !t_rw[hidx]));
  wire h_clean   = req_write && !t_d[hidx];
  wire [31:0] h_paddr = t_big[hidx] ? {t_frm[hidx][19:10], req_addr[21:0]}
                                    : {t_frm[hidx], req_addr[11:0]};
  wire accept    = req_valid && (st == S_IDLE);

  wire e_fault   = !ent[B_P] || (usr_q && (!ent[B_US] || (wr_q && !ent[B_RW])));
  wire at_dir    = (st == S_DCHK) || (st == S_DWR);
  wire leaf_dirty = wr_q && (!at_dir || ent[B_PS]);
  wire [31:0] need = ent | (32'd1 << B_A) | (leaf_dirty ? (32'd1 << B_D) : 32'd0);
  wire wb       = need != ent;

  wire fill_go = (st == S_DCHK && !e_fault && !wb && ent[B_PS]) ||
                 (st == S_DWR  && mem_ack && ent[B_PS]) ||
                 (st == S_TCHK && !e_fault && !wb) ||
                 (st == S_TWR  && mem_ack);
  wire f_rw = at_dir ? ent[B_RW] : (ent[B_RW] & pde_q[B_RW]);
  wire f_us = at_dir ? ent[B_US] : (ent[B_US] & pde_q[B_US]);

  assign busy      = st != S_IDLE;
  assign mem_req   = (st == S_DRD) || (st == S_DWR) || (st == S_TRD) || (st == S_TWR);
  assign mem_we    = (st == S_DWR) || (st == S_TWR);
  assign mem_addr  = at_dir || (st == S_DRD) ? {dir_base[31:12], va[31:22], 2'b00}
                                             : {pde_q[31:12], va[21:12], 2'b00};
  assign mem_wdata = ent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      res_done <= 1'b0;
      res_fault <= 1'b0;
      res_paddr <= '0;
      va <= '0; ent <= '0; pde_q <= '0;
      wr_q <= 1'b0; usr_q <= 1'b0; refill_hit <= 1'b0;
      fill_idx <= '0;
    end else begin
      res_done  <= 1'b0;
      res_fault <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          va    <= req_addr;
          wr_q  <= req_write;
          usr_q <= req_user;
          if (hit_ok && h_perm) res_fault <= 1'b1;
          else if (hit_ok && !h_clean) begin
            res_done  <= 1'b1;
            res_paddr <= h_paddr;
          end else begin
            st         <= S_DRD;
            refill_hit <= hit_ok;
            fill_idx   <= hit_ok ? hidx : rr;
          end
        end
        S_DRD: if (mem_ack) begin
          ent <= mem_rdata;
          st  <= S_DCHK;
        end
        S_DCHK: begin
          pde_q <= need;
          if (e_fault) begin
            res_fault <= 1'b1;
            st <= S_IDLE;
          end else if (wb) begin
            ent <= need;
            st  <= S_DWR;
          end else if (!ent[B_PS]) st <= S_TRD;
        end
        S_DWR: if (mem_ack && !ent[B_PS]) st <= S_TRD;
        S_TRD: if (mem_ack) begin
          ent <= mem_rdata;
          st  <= S_TCHK;
        end
        S_TCHK: begin
          if (e_fault) begin
            res_fault <= 1'b1;
            st <= S_IDLE;
          end else if (wb) begin
            ent <= need;
            st  <= S_TWR;
          end
        end
        default: ;
      endcase
      if (fill_go) begin
        res_done  <= 1'b1;
        res_paddr <= at_dir ? {ent[31:22], va[21:0]} : {ent[31:12], va[11:0]};
        st        <= S_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tv <= '0;
      rr <= '0;
    end else begin
      if (flush) tv <= '0;
      else if (fill_go) tv[fill_idx] <= 1'b1;
      if (fill_go && !refill_hit) rr <= (rr == IW'(TLB_N - 1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      t_vpn[fill_idx] <= va[31:12];
      t_frm[fill_idx] <= ent[31:12];
      t_big[fill_idx] <= at_dir;
      t_rw[fill_idx]  <= f_rw;
      t_us[fill_idx]  <= f_us;
      t_d[fill_idx]   <= ent[B_D];
    end
  end

  assert_single_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_done && res_fault));
  assert_start_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  assert_wb_used_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[B_A] && mem_wdata[B_P]);
  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> tv == '0);
  assert_hit_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_done && !$past(busy) |-> !mem_req);
endmodule

// File: tb/sim_page_walker.sv
module sim_page_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_user = 0, flush = 0;
  logic [31:0] req_addr = 0;
  logic [31:0] dir_base = 32'h0010_0000;
  logic busy, res_done, res_fault, mem_req, mem_we, mem_ack;
  logic [31:0] res_paddr, mem_addr, mem_wdata, mem_rdata;

  page_walker u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_user(req_user), .dir_base(dir_base), .flush(flush),
    .busy(busy), .res_done(res_done), .res_fault(res_fault), .res_paddr(res_paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  always #5 clk = ~clk;

  localparam logic [31:0] DIR = 32'h0010_0000;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [$];
  int rd_cnt = 0, wr_cnt = 0, lat = 0, total = 0, fails = 0, cyc = 0;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (lat == 0) begin
          mem_ack <= 1'b1;
          lat = $urandom % 3;
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata <= mrd(mem_addr);
            rd_cnt++;
            rd_log.push_back(mem_addr);
          end
        end else lat--;
      end
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, input bit w, input bit u,
                                output bit f, output logic [31:0] pa);
    logic [31:0] pde, pte;
    f = 0; pa = 0;
    pde = mrd(DIR + {20'h0, a[31:22], 2'b00});
    if (!pde[0] || (u && (!pde[2] || (w && !pde[1])))) begin f = 1; return; end
    if (pde[7]) begin pa = {pde[31:22], a[21:0]}; return; end
    pte = mrd({pde[31:12], a[21:12], 2'b00});
    if (!pte[0] || (u && (!pte[2] || (w && !pte[1])))) begin f = 1; return; end
    pa = {pte[31:12], a[11:0]};
  endfunction

  bit d, f, ef;
  logic [31:0] pa, epa;
  int nr, nw;

  task automatic xlate(input logic [31:0] a, input bit w, input bit u);
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    rd_log.delete();
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_user = u;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 200; k++) begin
      if (res_done || res_fault) break;
      @(negedge clk);
    end
    d = res_done; f = res_fault; pa = res_paddr;
    nr = rd_cnt - r0; nw = wr_cnt - w0;
    @(negedge clk);
  endtask

  task automatic do_flush;
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    mem[DIR + 0]  = 32'h0020_0007;
    mem[DIR + 4]  = 32'h0C80_0087;
    mem[DIR + 8]  = 32'h0;
    mem[DIR + 12] = 32'h0020_3007;
    mem[32'h0020_0004] = 32'h1234_5007;
    mem[32'h0020_0008] = 32'h0;
    mem[32'h0020_000C] = 32'h0033_3003;
    mem[32'h0020_0010] = 32'h0044_4005;
    for (int j = 0; j < 40; j++) mem[32'h0020_3000 + 4*j] = (32'h0005_0000 + j) << 12 | 32'h7;
    for (int di = 4; di < 8; di++) begin
      logic [31:0] r1, r2;
      bit p;
      r1 = $urandom; r2 = $urandom; p = ($urandom % 4) != 0;
      if ($urandom % 3 == 0)
        mem[DIR + 4*di] = (r1 & 32'hFFC0_0000) | 32'h80 | (r2 & 32'h66) | 32'(p);
      else begin
        mem[DIR + 4*di] = (32'h0021_0000 + di * 4096) | (r2 & 32'h26) | 32'(p);
        for (int j = 0; j < 8; j++) begin
          r1 = $urandom; r2 = $urandom; p = ($urandom % 4) != 0;
          mem[32'h0021_0000 + di * 4096 + 4*j] = (r1 & 32'hFFFF_F000) | (r2 & 32'h66) | 32'(p);
        end
      end
    end

    repeat (3) @(negedge clk);
    chk(!busy && !res_done && !res_fault && !mem_req, "R11 reset idle", {busy, res_done, res_fault, mem_req}, 0);
    rst_n = 1;

    xlate(32'h0000_1ABC, 0, 1);
    chk(d && pa == 32'h1234_5ABC, "R2 4KB paddr", pa, 32'h1234_5ABC);
    chk(rd_log.size() == 2 && rd_log[0] == DIR, "R1 dir read addr", rd_log.size() > 0 ? rd_log[0] : 0, DIR);
    chk(rd_log.size() == 2 && rd_log[1] == 32'h0020_0004, "R1 table read addr", rd_log.size() > 1 ? rd_log[1] : 0, 32'h0020_0004);
    chk(mem[DIR][5] && !mem[DIR][6], "R5 dir used set, no modified", mem[DIR], 32'h0020_0027);
    chk(mem[32'h0020_0004] == 32'h1234_5027, "R5 table used set on read", mem[32'h0020_0004], 32'h1234_5027);

    xlate(32'h0000_1004, 0, 1);
    chk(d && pa == 32'h1234_5004 && nr == 0 && nw == 0, "R7 hit no memory traffic", nr + nw, 0);

    xlate(32'h0000_1008, 1, 1);
    chk(d && pa == 32'h1234_5008, "R10 write-clean paddr", pa, 32'h1234_5008);
    chk(nr == 2 && nw == 1 && mem[32'h0020_0004] == 32'h1234_5067, "R10 walk sets modified", mem[32'h0020_0004], 32'h1234_5067);
    chk(!mem[DIR][6], "R5 non-leaf dir never modified", mem[DIR], 32'h0020_0027);
    xlate(32'h0000_100C, 1, 1);
    chk(d && nr == 0 && nw == 0, "R10 later write hits", nr + nw, 0);

    xlate(32'h0052_3456, 1, 0);
    chk(d && pa == 32'h0C92_3456, "R3 4MB paddr", pa, 32'h0C92_3456);
    chk(nr == 1 && mem[DIR + 4] == 32'h0C80_00E7, "R3 R5 one read, leaf dir used+modified", mem[DIR + 4], 32'h0C80_00E7);

    xlate(32'h0080_0000, 0, 0);
    chk(f && !d && nw == 0, "R4 dir not present fault", {f, d}, 2'b10);
    xlate(32'h0000_2000, 0, 0);
    chk(f && nr == 2 && nw == 0 && mem[32'h0020_0008] == 0, "R4 table not present fault", nw, 0);

    xlate(32'h0000_3010, 0, 1);
    chk(f, "R6 user on supervisor page", f, 1);
    xlate(32'h0000_3010, 0, 0);
    chk(d && pa == 32'h0033_3010, "R6 supervisor ignores user bit", pa, 32'h0033_3010);
    xlate(32'h0000_4020, 0, 1);
    chk(d && pa == 32'h0044_4020, "R6 user read of read-only", pa, 32'h0044_4020);
    xlate(32'h0000_4020, 1, 1);
    chk(f && nr == 0, "R6 user write read-only faults from cache", f, 1);
    xlate(32'h0000_4024, 1, 0);
    chk(d && nw == 1 && mem[32'h0020_0010][6], "R6 R10 supervisor write sets modified", mem[32'h0020_0010], 32'h0044_4065);

    do_flush();
    xlate(32'h0000_1ABC, 0, 1);
    chk(d && nr == 2, "R9 flush forces walk", nr, 2);

    do_flush();
    for (int j = 0; j < 33; j++) xlate(32'h00C0_0000 + (j << 12), 0, 1);
    xlate(32'h00C0_0000, 0, 1);
    chk(d && nr > 0 && pa == 32'h5000_0000, "R8 oldest entry evicted", nr, 2);
    xlate(32'h00C0_2000, 0, 1);
    chk(d && nr == 0 && pa == 32'h5000_2000, "R8 third page still cached", nr, 0);

    do_flush();
    begin
      int nres;
      logic [31:0] p1;
      nres = 0; p1 = 0;
      @(negedge clk); req_valid = 1; req_addr = 32'h0000_1111; req_write = 0; req_user = 0;
      @(negedge clk); req_valid = 0;
      chk(busy, "R11 busy during walk", busy, 1);
      req_valid = 1; req_addr = 32'h0052_0000;
      @(negedge clk); req_valid = 0;
      for (int k = 0; k < 60; k++) begin
        if (res_done || res_fault) begin nres++; p1 = res_paddr; end
        @(negedge clk);
      end
      chk(nres == 1 && p1 == 32'h1234_5111, "R11 request during busy ignored", p1, 32'h1234_5111);
    end

    for (int it = 0; it < 400; it++) begin
      logic [31:0] a, pde, leaf;
      bit w, u;
      a = {7'h0, 3'($urandom % 8), 7'h0, 3'($urandom % 8), 12'($urandom)};
      w = $urandom % 2; u = $urandom % 2;
      if ($urandom % 25 == 0) do_flush();
      model(a, w, u, ef, epa);
      xlate(a, w, u);
      chk(d == !ef && f == ef, "R4 R6 random outcome", {f, d}, {ef, !ef});
      if (!ef) begin
        chk(pa == epa, "R2 R3 random paddr", pa, epa);
        pde = mrd(DIR + {20'h0, a[31:22], 2'b00});
        leaf = pde[7] ? pde : mrd({pde[31:12], a[21:12], 2'b00});
        chk(pde[5] && leaf[5] && (!w || leaf[6]), "R5 random flags", leaf, leaf | 32'h20 | (w ? 32'h40 : 0));
      end
    end

    summary();
  end
endmodule